// File: doc/BRIEF.md
# Receive Signaling Change Queue

This block watches the per-channel ABCD signaling nibbles recovered from a receive T1 or E1 stream and hands a processor only the channels whose signaling moved. Upstream logic presents each channel's freshly extracted nibble together with its channel index. At each multiframe boundary the block walks the channels of the active line mode. Each enabled channel whose latest nibble differs from the value last reported for it is appended to a first-in, first-out queue as a (channel, nibble) entry.

After the walk, an interrupt flag is raised if any enabled channel differed. The processor then reads the queue word by word. Each entry comes out as a channel word followed by a nibble word. Every word carries a continuation flag, and the processor stops reading when that flag comes back clear. An optional setting raises the flag at every T1 boundary, so that software gets a multiframe-aligned tick. The flag is cleared by a write-one pulse.

Top module: `sig_change_queue`

## Requirements
- R1: A channel whose bit in `chan_en` is 0 during the boundary walk produces no queue entry and does not count as a change for the interrupt, whatever nibble it received.
- R2: Each channel keeps a stored copy of its last queued nibble, reset to 4'h0. The nibble compared at a boundary is the last one received for that channel since reset. The copy takes the compared nibble when the entry is queued.
- R3: The queue holds 32 entries, enough for all 30 E1 channels changing in one multiframe. When the queue is full, a changed channel is not queued and its stored copy stays as it was, so the change is reported at a later boundary once space exists.
- R4: With `e1_mode`=0 the walk covers channel indices 0 to 23. With `e1_mode`=1 it covers 0 to 29. Higher indices are never reported in that mode, but their received nibbles are kept.
- R5: The walk starts on the clock after `mf_strobe` and takes one cycle per channel. `irq` rises on the cycle after the walk ends, if at least one enabled channel differed. `irq` is 0 after reset.
- R6: An entry is read as two words. The first has `rd_word`=0 and the channel index in `rd_data`. The second has `rd_word`=1, the nibble in `rd_data[3:0]` and zeros above.
- R7: `rd_more` is 1 on a channel word. On a nibble word it is 1 only if further entries remain. A read of an empty queue returns `rd_word`=0, `rd_data`=0 and `rd_more`=0.
- R8: Entries leave the queue in the order they were queued. A channel that changes again before it was read gets a second entry, and the first entry is kept.
- R9: With `every_mf_irq`=1 and `e1_mode`=0, `irq` is set after every boundary walk even without a change. In E1 mode the setting has no effect.
- R10: A one-cycle pulse on `irq_clr` clears `irq`. A set in the same cycle takes priority.
- R11: Each `rd_req` pulse yields `rd_valid` with the read word on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| e1_mode | input | 1 | 0 = T1 (24 channels), 1 = E1 (30 channels) |
| every_mf_irq | input | 1 | Raise the interrupt at every T1 boundary |
| chan_en | input | 32 | Per-channel change capture enable |
| sig_valid | input | 1 | A received nibble is presented |
| sig_chan | input | 5 | Channel index of the presented nibble |
| sig_abcd | input | 4 | Received ABCD nibble |
| mf_strobe | input | 1 | Multiframe boundary pulse |
| rd_req | input | 1 | Read one queue word |
| rd_valid | output | 1 | Read word is present |
| rd_word | output | 1 | 0 = channel word, 1 = nibble word |
| rd_more | output | 1 | Further words remain to be read |
| rd_data | output | 5 | Channel index or nibble |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| irq | output | 1 | Signaling interrupt flag |

## Verification
The hardest state to reach is a full queue during a boundary walk, where changed channels must be skipped and their stored copies kept for a later report. The bench gets there by changing all thirty E1 channels in two consecutive multiframes without reading. It then drains the queue and crosses one more boundary to see the postponed entries. Random multiframes with random enables, modes and partial drains mix repeated changes and leftover entries around that case.

// File: rtl/sig_queue_pkg.sv
package sig_queue_pkg;
  localparam int ABCD_W = 4;
  typedef enum logic {WORD_CHAN = 1'b0, WORD_ABCD = 1'b1} word_sel_e;
endpackage

// File: rtl/sig_chan_table.sv
module sig_chan_table #(
  parameter int CH_W = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_valid,
  input  logic [CH_W-1:0]                    wr_chan,
  input  logic [sig_queue_pkg::ABCD_W-1:0]   wr_abcd,
  input  logic [CH_W-1:0]                    look_idx,
  input  logic                               commit,
  output logic [sig_queue_pkg::ABCD_W-1:0]   cur_val,
  output logic [sig_queue_pkg::ABCD_W-1:0]   ref_val
);
  import sig_queue_pkg::*;
  localparam int NCH = 1 << CH_W;

  logic [ABCD_W-1:0] cur_q [NCH];
  logic [ABCD_W-1:0] ref_q [NCH];

  // latest nibble received per channel
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) cur_q[i] <= '0;
    end else if (wr_valid) begin
      cur_q[wr_chan] <= wr_abcd;
    end
  end

  // last reported nibble per channel
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) ref_q[i] <= '0;
    end else if (commit) begin
      ref_q[look_idx] <= cur_q[look_idx];
    end
  end

  assign cur_val = cur_q[look_idx];
  assign ref_val = ref_q[look_idx];

  assert_commit_R2: assert property (@(posedge clk) disable iff (rst)
    commit |=> (ref_q[$past(look_idx)] == $past(cur_val)));
endmodule

// File: rtl/sig_scan_ctrl.sv
module sig_scan_ctrl #(
  parameter int CH_W  = 5,
  parameter int T1_CH = 24,
  parameter int E1_CH = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mf_strobe,
  input  logic            e1_mode,
  output logic            active,
  output logic            at_end,
  output logic            mode_e1,
  output logic [CH_W-1:0] idx
);
  localparam logic [CH_W-1:0] T1_LAST = CH_W'(T1_CH - 1);
  localparam logic [CH_W-1:0] E1_LAST = CH_W'(E1_CH - 1);

  logic [CH_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      last_q  <= T1_LAST;
      mode_e1 <= 1'b0;
    end else if (!active) begin
      if (mf_strobe) begin
        active  <= 1'b1;
        idx     <= '0;
        last_q  <= e1_mode ? E1_LAST : T1_LAST;
        mode_e1 <= e1_mode;
      end
    end else if (idx == last_q) begin
      active <= 1'b0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  assign at_end = active && (idx == last_q);

  assert_scan_range_R4: assert property (@(posedge clk) disable iff (rst)
    active |-> (idx <= (mode_e1 ? E1_LAST : T1_LAST)));
  assert_scan_step_R5: assert property (@(posedge clk) disable iff (rst)
    (active && !at_end) |=> (active && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/sig_entry_fifo.sv
module sig_entry_fifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_ptr_nxt;

  assign rd_ptr_nxt = rd_en ? rd_ptr + 1'b1 : rd_ptr;
  assign full       = (count == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  // registered read of the next head, write-first on a collision
  always_ff @(posedge clk) begin
    if (wr_en && (wr_ptr == rd_ptr_nxt)) head <= wr_data;
    else                                  head <= mem[rd_ptr_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_nxt;
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < (AW+1)'(DEPTH)));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (count != '0));
  assert_count_track_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/sig_read_port.sv
module sig_read_port #(
  parameter int CH_W = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_req,
  input  logic                              not_empty,
  input  logic                              more_after,
  input  logic [CH_W-1:0]                   head_chan,
  input  logic [sig_queue_pkg::ABCD_W-1:0]  head_abcd,
  output logic                              pop,
  output logic                              rd_valid,
  output logic                              rd_word,
  output logic                              rd_more,
  output logic [CH_W-1:0]                   rd_data
);
  import sig_queue_pkg::*;

  word_sel_e phase_q;

  assign pop = rd_req && not_empty && (phase_q == WORD_ABCD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= WORD_CHAN;
      rd_valid <= 1'b0;
      rd_word  <= 1'b0;
      rd_more  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        if (!not_empty) begin
          rd_word <= WORD_CHAN;
          rd_more <= 1'b0;
          rd_data <= '0;
        end else if (phase_q == WORD_CHAN) begin
          rd_word <= WORD_CHAN;
          rd_more <= 1'b1;
          rd_data <= head_chan;
          phase_q <= WORD_ABCD;
        end else begin
          rd_word <= WORD_ABCD;
          rd_more <= more_after;
          rd_data <= CH_W'(head_abcd);
          phase_q <= WORD_CHAN;
        end
      end
    end
  end

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  assert_abcd_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_word) |-> (rd_data[CH_W-1:ABCD_W] == '0));
  assert_chan_more_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_word && rd_more) |-> (phase_q == WORD_ABCD));
endmodule

// File: rtl/sig_change_queue.sv
module sig_change_queue #(
  parameter int CH_W  = 5,
  parameter int T1_CH = 24,
  parameter int E1_CH = 30,
  parameter int DEPTH = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 e1_mode,
  input  logic                 every_mf_irq,
  input  logic [(1<<CH_W)-1:0] chan_en,
  input  logic                 sig_valid,
  input  logic [CH_W-1:0]      sig_chan,
  input  logic [3:0]           sig_abcd,
  input  logic                 mf_strobe,
  input  logic                 rd_req,
  output logic                 rd_valid,
  output logic                 rd_word,
  output logic                 rd_more,
  output logic [CH_W-1:0]      rd_data,
  input  logic                 irq_clr,
  output logic                 irq
);
  import sig_queue_pkg::*;
  localparam int EW = CH_W + ABCD_W;
  localparam int CW = $clog2(DEPTH) + 1;

  logic              scan_active, scan_end, scan_e1;
  logic [CH_W-1:0]   scan_idx;
  logic [ABCD_W-1:0] cur_val, ref_val;
  logic              changed, push, pop, full, seen_q, irq_set;
  logic [EW-1:0]     head;
  logic [CW-1:0]     count;

  sig_scan_ctrl #(.CH_W(CH_W), .T1_CH(T1_CH), .E1_CH(E1_CH)) u_scan (
    .clk(clk), .rst(rst), .mf_strobe(mf_strobe), .e1_mode(e1_mode),
    .active(scan_active), .at_end(scan_end), .mode_e1(scan_e1), .idx(scan_idx));

  sig_chan_table #(.CH_W(CH_W)) u_table (
    .clk(clk), .rst(rst), .wr_valid(sig_valid), .wr_chan(sig_chan),
    .wr_abcd(sig_abcd), .look_idx(scan_idx), .commit(push),
    .cur_val(cur_val), .ref_val(ref_val));

  assign changed = scan_active && chan_en[scan_idx] && (cur_val != ref_val);
  assign push    = changed && !full;

  sig_entry_fifo #(.DW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data({scan_idx, cur_val}),
    .rd_en(pop), .head(head), .count(count), .full(full));

  sig_read_port #(.CH_W(CH_W)) u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req), .not_empty(count != '0),
    .more_after((count > CW'(1)) || push),
    .head_chan(head[EW-1:ABCD_W]), .head_abcd(head[ABCD_W-1:0]),
    .pop(pop), .rd_valid(rd_valid), .rd_word(rd_word),
    .rd_more(rd_more), .rd_data(rd_data));

  assign irq_set = scan_end && (seen_q || changed || (every_mf_irq && !scan_e1));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      seen_q <= (scan_active && !scan_end) ? (seen_q || changed) : 1'b0;
      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !irq_set) |=> !irq);
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(scan_end));
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (scan_active && !chan_en[scan_idx]) |-> !push);
endmodule

// File: tb/sig_change_queue_tb.sv
module sig_change_queue_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;

  logic clk = 0, rst = 1;
  logic e1_mode = 0, every_mf_irq = 0, sig_valid = 0, mf_strobe = 0;
  logic rd_req = 0, irq_clr = 0;
  logic [31:0] chan_en = '0;
  logic [4:0] sig_chan = '0, rd_data;
  logic [3:0] sig_abcd = '0;
  logic rd_valid, rd_word, rd_more, irq;

  always #(CLK_P/2) clk = ~clk;

  sig_change_queue u_dut (
    .clk(clk), .rst(rst), .e1_mode(e1_mode), .every_mf_irq(every_mf_irq),
    .chan_en(chan_en), .sig_valid(sig_valid), .sig_chan(sig_chan),
    .sig_abcd(sig_abcd), .mf_strobe(mf_strobe), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_word(rd_word), .rd_more(rd_more),
    .rd_data(rd_data), .irq_clr(irq_clr), .irq(irq));

  int n_chk = 0, n_fail = 0;
  logic [3:0] cur_m [32];
  logic [3:0] ref_m [32];
  logic [4:0] qc [DEPTH];
  logic [3:0] qv [DEPTH];
  int qn = 0;
  bit ph = 0, irq_m = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sample(int ch, logic [3:0] v);
    @(negedge clk);
    sig_valid = 1; sig_chan = 5'(ch); sig_abcd = v;
    @(negedge clk);
    sig_valid = 0;
    cur_m[ch] = v;
  endtask

  // boundary walk, then check the flag (R5, R9)
  task automatic boundary(string tag);
    int last;
    bit any;
    @(negedge clk);
    mf_strobe = 1;
    last = e1_mode ? 30 : 24;
    any = 0;
    for (int ch = 0; ch < last; ch++) begin
      if (chan_en[ch] && cur_m[ch] != ref_m[ch]) begin
        any = 1;
        if (qn < DEPTH) begin
          qc[qn] = 5'(ch); qv[qn] = cur_m[ch]; qn++;
          ref_m[ch] = cur_m[ch];
        end
      end
    end
    if (any || (every_mf_irq && !e1_mode)) irq_m = 1;
    @(negedge clk);
    mf_strobe = 0;
    repeat (34) @(negedge clk);
    check(irq == irq_m, tag, irq, irq_m);
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    irq_m = 0;
    check(irq == 0, "R10 clear", irq, 0);
  endtask

  task automatic read_word(output bit more);
    logic [4:0] ed;
    bit ew, em;
    @(negedge clk);
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    if (qn == 0) begin ew = 0; ed = 0; em = 0; end
    else if (!ph) begin ew = 0; ed = qc[0]; em = 1; ph = 1; end
    else begin
      ew = 1; ed = {1'b0, qv[0]}; em = (qn > 1); ph = 0;
      for (int i = 0; i < DEPTH-1; i++) begin qc[i] = qc[i+1]; qv[i] = qv[i+1]; end
      qn--;
    end
    check(rd_valid == 1, "R11 valid", rd_valid, 1);
    check(rd_word == ew, "R6 word select", rd_word, ew);
    check(rd_data == ed, "R6/R8 data", rd_data, ed);
    check(rd_more == em, "R7 more", rd_more, em);
    more = rd_more;
  endtask

  task automatic drain();
    bit m;
    m = 1;
    for (int g = 0; g < 100 && m; g++) read_word(m);
    check(qn == 0, "R7 drained", qn, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    bit m;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) begin cur_m[i] = 0; ref_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(irq == 0, "R5 reset irq", irq, 0);
    check(rd_valid == 0, "R11 reset valid", rd_valid, 0);

    read_word(m);                                       // R7 empty read

    chan_en = '1;
    sample(3, 4'h5); sample(10, 4'hA); sample(26, 4'h7);
    sample(10, 4'hC);                                   // R2 latest value wins
    boundary("R5 change irq");
    clear_irq();
    drain();                                            // R4 ch26 absent in T1

    chan_en[5] = 0;
    sample(5, 4'h9);
    boundary("R1 disabled no irq");
    read_word(m);                                       // R1 queue stays empty

    e1_mode = 1;
    boundary("R4 E1 range irq");                        // ch26 now reported
    clear_irq();
    drain();

    e1_mode = 0; chan_en = '1;
    boundary("R1 enable late");                         // ch5 now reported
    clear_irq();
    sample(7, 4'h1); boundary("R8 first");
    sample(7, 4'h2); boundary("R8 second");
    clear_irq();
    drain();                                            // R8 two entries kept

    every_mf_irq = 1;
    boundary("R9 T1 every boundary");
    clear_irq();
    e1_mode = 1;
    boundary("R9 no effect in E1");
    every_mf_irq = 0;

    for (int ch = 0; ch < 30; ch++) sample(ch, 4'(ch % 15 + 1) ^ cur_m[ch]);
    boundary("R3 fill");
    for (int ch = 0; ch < 30; ch++) sample(ch, 4'(ch % 15 + 1) ^ cur_m[ch]);
    boundary("R3 overflow");
    check(qn == DEPTH, "R3 queue full", qn, DEPTH);
    clear_irq();
    drain();
    boundary("R3 postponed report");
    clear_irq();
    drain();

    for (int it = 0; it < 40; it++) begin
      int ns;
      chan_en = $urandom;
      e1_mode = 1'($urandom);
      every_mf_irq = 1'($urandom);
      ns = $urandom % 12;
      for (int k = 0; k < ns; k++) sample($urandom % 32, 4'($urandom));
      boundary("R5 random");
      if ($urandom % 2) clear_irq();
      if ($urandom % 3 != 0) drain();
    end
    drain();
    finish_run();
  end
endmodule